// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block sits behind an SPI byte front end and turns the stream of received bytes into memory operations for a byte-wide nonvolatile array. It decodes six one-byte instructions: set and clear a write-enable latch, read and write a status byte, read data and write data. A data read streams bytes from a running address that covers the whole array. A data write gathers up to one page of bytes in a local buffer. It programs them only when chip select rises exactly on a byte boundary.

Once a write is committed, a self-timed write cycle of a parameterised number of clocks begins. During that window the buffered page is drained into the array through a write port. Each byte is first checked against an external protection unit, and bytes that it refuses are dropped. Only status reads are honoured while the cycle runs. The array sits outside the block and is reached through a read address / read data pair and a write port. The protection unit receives the three protection bits held in the status byte, and it also decides whether a status write may take effect.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: After reset, txEn, abortFlag, busy and memWe are 0 and protBits is 000.
- R2: An opcode byte is decoded from its upper nibble (must be 0000) and bits 2..0, and bit 3 is ignored. Bits 2..0 = 110 set the write-enable latch and 100 clear it, each taking effect once that byte is received. The latch value shows in bit 1 of the status byte.
- R3: Bits 2..0 = 101 (read status) make txByte carry {protect-enable, 0, 0, 0, protect-hi, protect-lo, latch, 0} with txEn high, one cycle after the opcode and after every later byte. While busy, the status byte reads 8'hFF.
- R4: Bits 2..0 = 011 (read) take a 16-bit address, high byte first. txByte carries the addressed byte two cycles after the last address byte. Each further received byte advances the address by one, and the address wraps from FFFFh to 0000h. txEn is low the cycle after any chip-select edge.
- R5: Bits 2..0 = 010 (write) take a 16-bit address and then data bytes. Each byte goes to the current address, and only the low 7 address bits advance, so the upper bits stay fixed. Past 128 bytes, earlier bytes of the page are overwritten.
- R6: A write is committed only when csRise arrives with rxPartial low and at least one data byte has been received. Otherwise the buffered bytes are discarded and nothing is programmed.
- R7: A write opcode received while the latch is clear is ignored, with no commit at csRise.
- R8: After a commit, busy goes high on the next cycle and stays high for exactly TWC_CYCLES clocks.
- R9: While busy, every opcode other than read status is ignored: a read produces no txEn, and an invalid opcode does not raise abortFlag.
- R10: The write-enable latch is clear when the write cycle ends.
- R11: An opcode with a non-zero upper nibble or with bits 2..0 of 000 or 111 raises abortFlag. The flag stays high across chip-select rises until the next csFall.
- R12: During the write cycle, each buffered byte is written through memWe only if chkAllowed is high for its address. Refused bytes of the same page are dropped while allowed ones are still written. memWe is active only while busy.
- R13: Bits 2..0 = 001 (status write) with the latch set take the first following data byte. On a commit that is aligned and made while srAllowed is high, its bits 7, 3 and 2 become protBits[2:0] (protect-enable, protect-hi, protect-lo) at the end of the write cycle. With srAllowed low there is no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxByte | input | 8 | Byte received by the front end |
| rxValid | input | 1 | One-cycle strobe: rxByte complete |
| rxPartial | input | 1 | Front end holds a partially shifted byte |
| csFall | input | 1 | One-cycle chip-select assertion event |
| csRise | input | 1 | One-cycle chip-select release event |
| srAllowed | input | 1 | Protection unit permits a status write |
| chkAllowed | input | 1 | Protection unit permits a write to chkAddr |
| memRData | input | 8 | Array read data for memRAddr |
| txByte | output | 8 | Byte for the front end to shift out |
| txEn | output | 1 | txByte is valid for output |
| abortFlag | output | 1 | Invalid opcode seen in this selection |
| busy | output | 1 | Self-timed write cycle in progress |
| protBits | output | 3 | Protect-enable, protect-hi, protect-lo |
| memRAddr | output | ADDR_W | Array read address |
| memWe | output | 1 | Array write strobe |
| memWAddr | output | ADDR_W | Array write address |
| memWData | output | 8 | Array write data |
| chkAddr | output | ADDR_W | Address offered to the protection unit |

## Verification
Status bytes are due one cycle after the received byte, array bytes two cycles after the byte that completes or advances the address, and busy one cycle after the committing csRise. Abort and latch changes appear one cycle after the opcode. Each byte stimulus is followed by two idle clocks, and outputs are sampled on the falling edge, so every registered result has settled before a scoreboard entry is popped and compared. Busy is counted one falling edge at a time from the edge that follows the commit, and array contents are inspected only after busy has fallen.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  localparam logic [2:0] OP_SET_WE  = 3'b110;
  localparam logic [2:0] OP_CLR_WE  = 3'b100;
  localparam logic [2:0] OP_RD_STAT = 3'b101;
  localparam logic [2:0] OP_WR_STAT = 3'b001;
  localparam logic [2:0] OP_RD_DATA = 3'b011;
  localparam logic [2:0] OP_WR_DATA = 3'b010;

  typedef enum logic [2:0] {
    ST_SKIP,
    ST_OPCODE,
    ST_ADDR,
    ST_READ,
    ST_WRITE,
    ST_SRDATA,
    ST_STATUS
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic addrShift;
    logic readStart;
    logic readNext;
    logic pageStore;
    logic pageCommit;
    logic pageClear;
    logic statusLoad;
    logic txOff;
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int TWC_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rxByte,
  input  logic       rxValid,
  input  logic       rxPartial,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       srAllowed,
  output dpStrobe_t  stb,
  output logic [7:0] statusByte,
  output logic       busy,
  output logic       abortFlag,
  output logic [2:0] protBits
);

  localparam int AC_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int BC_W = $clog2(TWC_CYCLES + 1);

  seqState_e       state;
  logic            isWrite;
  logic [AC_W-1:0] addrCnt;
  logic            dataSeen;
  logic            wen;
  logic            wpen, bpHi, bpLo;
  logic [2:0]      srShadow;
  logic            srPend;
  logic [BC_W-1:0] busyCnt;
  logic            abortQ;

  logic [2:0] opLow;
  logic       opKnown;
  logic       lastAddr;
  logic       pageCommitOk;
  logic       srCommitOk;

  assign opLow    = rxByte[2:0];
  assign opKnown  = (rxByte[7:4] == 4'h0) && (opLow != 3'b000) && (opLow != 3'b111);
  assign lastAddr = (addrCnt == AC_W'(ADDR_BYTES - 1));
  assign busy     = (busyCnt != '0);

  assign pageCommitOk = csRise && (state == ST_WRITE) && dataSeen && !rxPartial;
  assign srCommitOk   = csRise && (state == ST_SRDATA) && dataSeen && !rxPartial && srAllowed;

  assign statusByte = busy ? 8'hFF : {wpen, 3'b000, bpHi, bpLo, wen, 1'b0};
  assign abortFlag  = abortQ;
  assign protBits   = {wpen, bpHi, bpLo};

  always_comb begin
    stb            = '0;
    stb.txOff      = csFall | csRise;
    stb.pageCommit = pageCommitOk;
    stb.pageClear  = csRise && (state == ST_WRITE) && !pageCommitOk;
    if (rxValid && !csFall && !csRise) begin
      unique case (state)
        ST_OPCODE: stb.statusLoad = opKnown && (opLow == OP_RD_STAT);
        ST_ADDR: begin
          stb.addrShift = 1'b1;
          stb.readStart = lastAddr && !isWrite;
        end
        ST_READ:   stb.readNext   = 1'b1;
        ST_WRITE:  stb.pageStore  = 1'b1;
        ST_STATUS: stb.statusLoad = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_SKIP;
      isWrite  <= 1'b0;
      addrCnt  <= '0;
      dataSeen <= 1'b0;
      wen      <= 1'b0;
      wpen     <= 1'b0;
      bpHi     <= 1'b0;
      bpLo     <= 1'b0;
      srShadow <= '0;
      srPend   <= 1'b0;
      busyCnt  <= '0;
      abortQ   <= 1'b0;
    end else begin
      if (busy) begin
        busyCnt <= busyCnt - 1'b1;
        if (busyCnt == BC_W'(1)) begin
          wen <= 1'b0;
          if (srPend) begin
            {wpen, bpHi, bpLo} <= srShadow;
            srPend             <= 1'b0;
          end
        end
      end
      if (csFall) begin
        state    <= ST_OPCODE;
        abortQ   <= 1'b0;
        dataSeen <= 1'b0;
      end else if (csRise) begin
        state <= ST_SKIP;
        if (pageCommitOk) busyCnt <= BC_W'(TWC_CYCLES);
        if (srCommitOk) begin
          busyCnt <= BC_W'(TWC_CYCLES);
          srPend  <= 1'b1;
        end
      end else if (rxValid) begin
        unique case (state)
          ST_OPCODE: begin
            if (busy) begin
              state <= (opKnown && opLow == OP_RD_STAT) ? ST_STATUS : ST_SKIP;
            end else if (!opKnown) begin
              abortQ <= 1'b1;
              state  <= ST_SKIP;
            end else begin
              state <= ST_SKIP;
              unique case (opLow)
                OP_SET_WE:  wen <= 1'b1;
                OP_CLR_WE:  wen <= 1'b0;
                OP_RD_STAT: state <= ST_STATUS;
                OP_WR_STAT: if (wen) state <= ST_SRDATA;
                OP_RD_DATA: begin
                  isWrite <= 1'b0;
                  addrCnt <= '0;
                  state   <= ST_ADDR;
                end
                OP_WR_DATA: if (wen) begin
                  isWrite <= 1'b1;
                  addrCnt <= '0;
                  state   <= ST_ADDR;
                end
                default: ;
              endcase
            end
          end
          ST_ADDR: begin
            if (lastAddr) state <= isWrite ? ST_WRITE : ST_READ;
            else addrCnt <= addrCnt + 1'b1;
          end
          ST_WRITE: dataSeen <= 1'b1;
          ST_SRDATA: begin
            if (!dataSeen) srShadow <= {rxByte[7], rxByte[3], rxByte[2]};
            dataSeen <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_BUSY_FROM_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise)); // R8
  AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wen); // R10
  AST_ABORT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    abortQ && !csFall |=> abortQ); // R11
  AST_BUSY_NO_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    busy && rxValid && !csFall && !csRise && state == ST_OPCODE && !abortQ |=> !abortQ); // R9

endmodule

// File: rtl/eeprom_seq_dp.sv
module eeprom_seq_dp
  import eeprom_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        rxByte,
  input  logic [7:0]        statusByte,
  input  logic [7:0]        memRData,
  input  logic              chkAllowed,
  output logic [7:0]        txByte,
  output logic              txEn,
  output logic [ADDR_W-1:0] memRAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memWAddr,
  output logic [7:0]        memWData,
  output logic [ADDR_W-1:0] chkAddr
);

  localparam int PAGE_SZ = 1 << PAGE_W;

  logic [ADDR_W-1:0]  curAddr;
  logic [7:0]         pageBuf [PAGE_SZ];
  logic [PAGE_SZ-1:0] pageVld;
  logic               draining;
  logic [PAGE_W-1:0]  drainIdx;
  logic               fetchPend;

  assign memRAddr = curAddr;
  assign chkAddr  = {curAddr[ADDR_W-1:PAGE_W], drainIdx};
  assign memWAddr = chkAddr;
  assign memWData = pageBuf[drainIdx];
  assign memWe    = draining && pageVld[drainIdx] && chkAllowed;

  always_ff @(posedge clk) begin
    if (stb.pageStore) pageBuf[curAddr[PAGE_W-1:0]] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      pageVld   <= '0;
      draining  <= 1'b0;
      drainIdx  <= '0;
      fetchPend <= 1'b0;
      txByte    <= '0;
      txEn      <= 1'b0;
    end else begin
      fetchPend <= (stb.readStart | stb.readNext) & ~stb.txOff;
      if (stb.addrShift) curAddr <= ADDR_W'({curAddr, rxByte});
      if (stb.readNext)  curAddr <= curAddr + 1'b1;
      if (stb.pageStore) begin
        pageVld[curAddr[PAGE_W-1:0]] <= 1'b1;
        curAddr[PAGE_W-1:0]          <= curAddr[PAGE_W-1:0] + 1'b1;
      end
      if (stb.pageClear) pageVld <= '0;
      if (stb.pageCommit) begin
        draining <= 1'b1;
        drainIdx <= '0;
      end else if (draining) begin
        drainIdx <= drainIdx + 1'b1;
        if (drainIdx == PAGE_W'(PAGE_SZ - 1)) begin
          draining <= 1'b0;
          pageVld  <= '0;
        end
      end
      if (fetchPend && !stb.txOff) begin
        txByte <= memRData;
        txEn   <= 1'b1;
      end
      if (stb.statusLoad) begin
        txByte <= statusByte;
        txEn   <= 1'b1;
      end
      if (stb.txOff) txEn <= 1'b0;
    end
  end

  AST_PAGE_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    stb.pageStore |=> curAddr[ADDR_W-1:PAGE_W] == $past(curAddr[ADDR_W-1:PAGE_W])); // R5

endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
  import eeprom_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 7,
  parameter int TWC_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rxByte,
  input  logic              rxValid,
  input  logic              rxPartial,
  input  logic              csFall,
  input  logic              csRise,
  input  logic              srAllowed,
  input  logic              chkAllowed,
  input  logic [7:0]        memRData,
  output logic [7:0]        txByte,
  output logic              txEn,
  output logic              abortFlag,
  output logic              busy,
  output logic [2:0]        protBits,
  output logic [ADDR_W-1:0] memRAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memWAddr,
  output logic [7:0]        memWData,
  output logic [ADDR_W-1:0] chkAddr
);

  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;

  dpStrobe_t  stb;
  logic [7:0] statusByte;

  eeprom_seq_ctrl #(
    .ADDR_BYTES(ADDR_BYTES),
    .TWC_CYCLES(TWC_CYCLES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxByte    (rxByte),
    .rxValid   (rxValid),
    .rxPartial (rxPartial),
    .csFall    (csFall),
    .csRise    (csRise),
    .srAllowed (srAllowed),
    .stb       (stb),
    .statusByte(statusByte),
    .busy      (busy),
    .abortFlag (abortFlag),
    .protBits  (protBits)
  );

  eeprom_seq_dp #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rxByte    (rxByte),
    .statusByte(statusByte),
    .memRData  (memRData),
    .chkAllowed(chkAllowed),
    .txByte    (txByte),
    .txEn      (txEn),
    .memRAddr  (memRAddr),
    .memWe     (memWe),
    .memWAddr  (memWAddr),
    .memWData  (memWData),
    .chkAddr   (chkAddr)
  );

  AST_WRITE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R12
  AST_TX_OFF_AFTER_RISE: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> !txEn); // R4

endmodule

// File: tb/test_eeprom_cmd_seq.sv
`timescale 1ns/1ps
module test_eeprom_cmd_seq;

  localparam int TWC = 200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxValid = 1'b0, rxPartial = 1'b0, csFall = 1'b0, csRise = 1'b0;
  logic        srAllowed = 1'b1;
  logic        chkAllowed;
  logic [7:0]  memRData = '0;
  logic [7:0]  txByte;
  logic        txEn, abortFlag, busy, memWe;
  logic [2:0]  protBits;
  logic [15:0] memRAddr, memWAddr, chkAddr;
  logic [7:0]  memWData;
  logic        blockOdd = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [7:0] dutMem [int];
  logic [7:0] expVal [$];
  string      expTag [$];
  event       txEv;

  always #2 clk = ~clk;

  eeprom_cmd_seq i_eeprom_cmd_seq (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid), .rxPartial(rxPartial),
    .csFall(csFall), .csRise(csRise), .srAllowed(srAllowed), .chkAllowed(chkAllowed),
    .memRData(memRData), .txByte(txByte), .txEn(txEn), .abortFlag(abortFlag), .busy(busy),
    .protBits(protBits), .memRAddr(memRAddr), .memWe(memWe), .memWAddr(memWAddr),
    .memWData(memWData), .chkAddr(chkAddr)
  );

  function automatic logic [7:0] initVal(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rdMem(input logic [15:0] a);
    if (dutMem.exists(int'(a))) return dutMem[int'(a)];
    return initVal(a);
  endfunction

  function automatic logic allowFn(input logic [2:0] p, input logic [15:0] a, input logic odd);
    logic prot;
    case (p[1:0])
      2'b00:   prot = 1'b0;
      2'b01:   prot = (a >= 16'hC000);
      2'b10:   prot = (a >= 16'h8000);
      default: prot = 1'b1;
    endcase
    if (odd && a[0]) prot = 1'b1;
    return !prot;
  endfunction

  assign chkAllowed = allowFn(protBits, chkAddr, blockOdd);

  always @(negedge clk) begin
    memRData <= rdMem(memRAddr);
    if (memWe) dutMem[int'(memWAddr)] = memWData;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(txEv);
      while (expVal.size() > 0) begin
        logic [7:0] e;
        string t;
        e = expVal.pop_front();
        t = expTag.pop_front();
        check(txEn && txByte == e, t, {txEn, txByte}, {1'b1, e});
      end
    end
  end

  task automatic expectTx(input logic [7:0] v, input string tag);
    expVal.push_back(v);
    expTag.push_back(tag);
    -> txEv;
    #0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxByte = b; rxValid = 1'b1;
    @(negedge clk); rxValid = 1'b0;
    tick(2);
  endtask

  task automatic csLow();
    @(negedge clk); csFall = 1'b1;
    @(negedge clk); csFall = 1'b0;
    tick(1);
  endtask

  task automatic csHigh(input bit partial);
    @(negedge clk); csRise = 1'b1; rxPartial = partial;
    @(negedge clk); csRise = 1'b0; rxPartial = 1'b0;
  endtask

  task automatic oneOp(input logic [7:0] op);
    csLow(); sendByte(op); csHigh(1'b0);
  endtask

  task automatic readStatus(input logic [7:0] e, input string tag);
    csLow(); sendByte(8'h05); expectTx(e, tag);
    sendByte(8'h00); expectTx(e, tag);
    csHigh(1'b0);
  endtask

  task automatic writeBytes(input logic [15:0] a, input logic [7:0] d[$], input bit partial);
    csLow(); sendByte(8'h02); sendByte(a[15:8]); sendByte(a[7:0]);
    foreach (d[i]) sendByte(d[i]);
    csHigh(partial);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic countBusy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R8 actual=running expected=finished");
    summary();
  end

  initial begin
    int n;
    logic [7:0] q[$];
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    check(txEn == 0 && abortFlag == 0 && busy == 0 && memWe == 0 && protBits == 0, "R1",
          {txEn, abortFlag, busy, memWe, protBits}, 0);

    // R3 status after reset
    readStatus(8'h00, "R3 idle status");

    // R2 latch set with bit 3 set, then clear
    oneOp(8'h0E);
    readStatus(8'h02, "R2 latch set");
    oneOp(8'h0C);
    readStatus(8'h00, "R2 latch cleared");

    // R5 page write with wrap in low 7 bits, R8 busy length, R10 latch clear
    oneOp(8'h06);
    q = '{8'hAA, 8'hBB, 8'hCC};
    writeBytes(16'h127E, q, 1'b0);
    countBusy(n);
    check(n == TWC, "R8 busy length", n, TWC);
    readStatus(8'h00, "R10 latch cleared after cycle");
    check(rdMem(16'h127E) == 8'hAA, "R5 byte0", rdMem(16'h127E), 8'hAA);
    check(rdMem(16'h127F) == 8'hBB, "R5 byte1", rdMem(16'h127F), 8'hBB);
    check(rdMem(16'h1200) == 8'hCC, "R5 page wrap", rdMem(16'h1200), 8'hCC);
    check(rdMem(16'h1280) == initVal(16'h1280), "R5 next page untouched", rdMem(16'h1280), initVal(16'h1280));

    // R4 read with full increment
    csLow(); sendByte(8'h03); sendByte(8'h12); sendByte(8'h7E);
    expectTx(8'hAA, "R4 read first");
    sendByte(8'h00); expectTx(8'hBB, "R4 read incr");
    sendByte(8'h00); expectTx(initVal(16'h1280), "R4 read crosses page");
    csHigh(1'b0);
    check(txEn == 0, "R4 txEn off after rise", txEn, 0);
    // R4 wrap at top
    csLow(); sendByte(8'h0B); sendByte(8'hFF); sendByte(8'hFF);
    expectTx(initVal(16'hFFFF), "R4 read top");
    sendByte(8'h00); expectTx(initVal(16'h0000), "R4 read wrap");
    csHigh(1'b0);

    // R9 ignore during busy, R3 FF while busy
    oneOp(8'h06);
    q = '{8'h11};
    writeBytes(16'h0500, q, 1'b0);
    check(busy == 1, "R8 busy after commit", busy, 1);
    csLow(); sendByte(8'h03); sendByte(8'h00); sendByte(8'h00); sendByte(8'h00);
    check(txEn == 0, "R9 read ignored while busy", txEn, 0);
    csHigh(1'b0);
    csLow(); sendByte(8'h07);
    check(abortFlag == 0, "R9 invalid ignored while busy", abortFlag, 0);
    csHigh(1'b0);
    readStatus(8'hFF, "R3 status while busy");
    waitIdle();
    check(rdMem(16'h0500) == 8'h11, "R12 allowed byte written", rdMem(16'h0500), 8'h11);
    readStatus(8'h00, "R10 latch clear");

    // R7 write without latch
    q = '{8'h22};
    writeBytes(16'h0600, q, 1'b0);
    check(busy == 0, "R7 no commit", busy, 0);
    tick(TWC + 10);
    check(rdMem(16'h0600) == initVal(16'h0600), "R7 memory unchanged", rdMem(16'h0600), initVal(16'h0600));

    // R6 misaligned rise and empty write
    oneOp(8'h06);
    q = '{8'h33};
    writeBytes(16'h0700, q, 1'b1);
    check(busy == 0, "R6 misaligned no commit", busy, 0);
    q = {};
    writeBytes(16'h0710, q, 1'b0);
    check(busy == 0, "R6 no data no commit", busy, 0);
    tick(TWC + 10);
    check(rdMem(16'h0700) == initVal(16'h0700), "R6 memory unchanged", rdMem(16'h0700), initVal(16'h0700));

    // R11 invalid opcodes
    csLow(); sendByte(8'h07);
    check(abortFlag == 1, "R11 abort raised", abortFlag, 1);
    csHigh(1'b0); tick(2);
    check(abortFlag == 1, "R11 abort held over rise", abortFlag, 1);
    csLow();
    check(abortFlag == 0, "R11 abort cleared on fall", abortFlag, 0);
    sendByte(8'h16);
    check(abortFlag == 1, "R11 upper nibble abort", abortFlag, 1);
    csHigh(1'b0);
    csLow(); csHigh(1'b0);

    // R5 overflow past a page
    oneOp(8'h06);
    q = {};
    for (int i = 0; i < 130; i++) q.push_back(8'(i));
    writeBytes(16'h0400, q, 1'b0);
    waitIdle();
    check(rdMem(16'h0400) == 8'h80, "R5 overwrite slot0", rdMem(16'h0400), 8'h80);
    check(rdMem(16'h0401) == 8'h81, "R5 overwrite slot1", rdMem(16'h0401), 8'h81);
    check(rdMem(16'h0402) == 8'h02, "R5 kept slot2", rdMem(16'h0402), 8'h02);
    check(rdMem(16'h047F) == 8'h7F, "R5 last slot", rdMem(16'h047F), 8'h7F);
    check(rdMem(16'h0480) == initVal(16'h0480), "R5 no spill", rdMem(16'h0480), initVal(16'h0480));

    // R13 status write
    oneOp(8'h06);
    csLow(); sendByte(8'h01); sendByte(8'h8C); csHigh(1'b0);
    waitIdle();
    check(protBits == 3'b111, "R13 protBits set", protBits, 3'b111);
    readStatus(8'h8C, "R13 status image");
    oneOp(8'h06);
    srAllowed = 1'b0;
    csLow(); sendByte(8'h01); sendByte(8'h04); csHigh(1'b0);
    check(busy == 0, "R13 refused status write", busy, 0);
    srAllowed = 1'b1;
    readStatus(8'h8E, "R13 status unchanged");
    csLow(); sendByte(8'h01); sendByte(8'h04); csHigh(1'b0);
    waitIdle();
    check(protBits == 3'b001, "R13 protBits quarter", protBits, 3'b001);

    // R12 per-address drop
    blockOdd = 1'b1;
    oneOp(8'h06);
    q = '{8'h40, 8'h41, 8'h42, 8'h43};
    writeBytes(16'h0300, q, 1'b0);
    waitIdle();
    check(rdMem(16'h0300) == 8'h40, "R12 even written", rdMem(16'h0300), 8'h40);
    check(rdMem(16'h0301) == initVal(16'h0301), "R12 odd dropped", rdMem(16'h0301), initVal(16'h0301));
    check(rdMem(16'h0302) == 8'h42, "R12 even written 2", rdMem(16'h0302), 8'h42);
    blockOdd = 1'b0;
    oneOp(8'h06);
    q = '{8'h55};
    writeBytes(16'hC010, q, 1'b0);
    waitIdle();
    check(rdMem(16'hC010) == initVal(16'hC010), "R12 protected quarter", rdMem(16'hC010), initVal(16'hC010));

    tick(4);
    summary();
  end

endmodule